// File: doc/BRIEF.md
# Touch Matrix Burst Scan Sequencer

This block sequences the drive and gating waveforms for an 8-by-4 matrix of charge-transfer touch keys. It visits the 32 keys one after another. For each key it pulses one X drive line with a burst of positive-going pulses. Around every rising edge it opens the matching active-high Y sample gate, and it drives complementary grounding outputs so that the unselected Y lines can be tied to ground. All timing is counted in system clock cycles.

Each key has its own 4-bit burst gain and its own 4-bit gate dwell. Both arrive as flat configuration vectors and are captured once, at the start of that key's scan. Before each burst the block gives a one-cycle reset pulse for the sample capacitor. After the last pulse it gives a one-cycle conversion strobe carrying the key index, which an external converter uses. The analog switches, the conversion itself, thresholding and charge cancellation all live outside this block.

Top module: `tm_burst_scan`

## Requirements
- R1: While `rst_i` is high and after it is released, all X drives and Y gates are low, all grounding outputs are high, both pulse outputs are low, `conv_key_o` is 0, and scanning restarts at key 0. The first capacitor reset pulse appears on the second rising edge after release.
- R2: The key index equals X × 4 + Y, where the X line is index bits [4:2] and the Y line is bits [1:0]. Keys are scanned in order 0, 1, …, 31, then wrap to 0, with no idle cycles between keys.
- R3: At most one X drive and at most one Y gate are high in any cycle, and `y_gnd_o` is always the bitwise inverse of `y_gate_o`.
- R4: A key's burst has 4 × (gain + 1) pulses, where gain is `key_gain_i[4k+3:4k]` for key k.
- R5: Each pulse occupies a 24-cycle slot. The selected Y gate is high in slot cycles 0 and 1, before X rises at slot cycle 2.
- R6: After the X rise the Y gate stays high for exactly d cycles, counting the rise cycle, where d is `key_dwell_i[4k+3:4k]` and a value of 0 acts as 1. This holds whatever the X width or the pulse spacing.
- R7: The X drive is high in slot cycles 2 to 9 (8 cycles) and low for the other 16, so rising edges are 24 cycles apart.
- R8: `cap_reset_o` is high for exactly the one cycle before the first Y gate of each burst.
- R9: `conv_strobe_o` is high for exactly the one cycle after the last slot of a burst, with `conv_key_o` equal to that key's index. The next key's capacitor reset follows in the next cycle.
- R10: Gain and dwell are captured in the cycle in which `cap_reset_o` becomes visible. Changes made after that point have no effect on the burst in progress, but they do take effect for later keys.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| key_gain_i | input | 128 | Per-key gain, 4 bits per key, key k at bits [4k+3:4k] |
| key_dwell_i | input | 128 | Per-key gate dwell in cycles, 4 bits per key |
| x_drive_o | output | 8 | X drive lines, active high |
| y_gate_o | output | 4 | Y sample gates, active high |
| y_gnd_o | output | 4 | Inverted Y gates for grounding unselected lines |
| cap_reset_o | output | 1 | One-cycle sample capacitor reset before each burst |
| conv_strobe_o | output | 1 | One-cycle conversion strobe after each burst |
| conv_key_o | output | 5 | Key index reported with the strobe |

## Verification
Every output comes from a register fed by the sequencer state, so every result appears one rising edge after the state that causes it. The first capacitor reset is therefore due on the second edge after reset release, and each later waveform position follows at exactly one cycle per position. The bench samples on falling edges and steps a reference timeline computed from the requirements by one position per cycle, starting one idle position after release. Configuration changes are applied only after the falling-edge comparison that sees the capacitor reset, so they fall after the capture edge.

// File: rtl/tm_scan_pkg.sv
package tm_scan_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_PRECHG = 2'd1,
      ST_BURST  = 2'd2,
      ST_STROBE = 2'd3
   } scan_state_e;

   function automatic int unsigned width_of(input int unsigned count);
      return (count <= 1) ? 1 : $clog2(count);
   endfunction

endpackage

// File: rtl/tm_cfg_select.sv
module tm_cfg_select #(
   parameter int NUM_KEYS = 32,
   parameter int KEY_W    = 5,
   parameter int GAIN_W   = 4,
   parameter int DWELL_W  = 4
) (
   input  logic                         clk_i,
   input  logic                         rst_i,
   input  logic                         load_i,
   input  logic [KEY_W-1:0]             key_i,
   input  logic [NUM_KEYS*GAIN_W-1:0]   gain_flat_i,
   input  logic [NUM_KEYS*DWELL_W-1:0]  dwell_flat_i,
   output logic [GAIN_W-1:0]            gain_o,
   output logic [DWELL_W-1:0]           dwell_o
);

   logic [GAIN_W-1:0]  gain_tab  [NUM_KEYS];
   logic [DWELL_W-1:0] dwell_tab [NUM_KEYS];
   logic [GAIN_W-1:0]  gain_sel;
   logic [DWELL_W-1:0] dwell_sel;
   logic [DWELL_W-1:0] dwell_eff;

   for (genvar k = 0; k < NUM_KEYS; k++) begin : g_unpack
      assign gain_tab[k]  = gain_flat_i[k*GAIN_W +: GAIN_W];
      assign dwell_tab[k] = dwell_flat_i[k*DWELL_W +: DWELL_W];
   end

   always_comb begin
      gain_sel  = '0;
      dwell_sel = '0;
      if (32'(key_i) < NUM_KEYS) begin
         gain_sel  = gain_tab[key_i];
         dwell_sel = dwell_tab[key_i];
      end
      dwell_eff = (dwell_sel == '0) ? DWELL_W'(1) : dwell_sel;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         gain_o  <= '0;
         dwell_o <= DWELL_W'(1);
      end else if (load_i) begin
         gain_o  <= gain_sel;
         dwell_o <= dwell_eff;
      end
   end

   // R6: the captured dwell is never zero
   a_r6_dwell_nonzero: assert property (@(posedge clk_i) disable iff (rst_i)
      dwell_o != '0);

endmodule

// File: rtl/tm_slot_timer.sv
module tm_slot_timer #(
   parameter int SLOT_CYC        = 24,
   parameter int GAIN_W          = 4,
   parameter int PULSES_PER_GAIN = 4,
   parameter int PULSE_W         = 7,
   parameter int T_W             = 5
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               clr_i,
   input  logic               run_i,
   input  logic [GAIN_W-1:0]  gain_i,
   output logic [T_W-1:0]     t_o,
   output logic               done_o
);

   localparam logic [T_W-1:0] T_LAST = T_W'(SLOT_CYC - 1);
   localparam int             LOG_PPG = (PULSES_PER_GAIN <= 1) ? 0 : $clog2(PULSES_PER_GAIN);

   logic [PULSE_W-1:0] gain_plus1;
   logic [PULSE_W-1:0] n_pulses;
   logic [PULSE_W-1:0] p_q;
   logic [T_W-1:0]     t_q;

   assign gain_plus1 = PULSE_W'(gain_i) + PULSE_W'(1);

   if ((PULSES_PER_GAIN & (PULSES_PER_GAIN - 1)) == 0) begin : g_shift
      assign n_pulses = gain_plus1 << LOG_PPG;
   end else begin : g_mult
      assign n_pulses = gain_plus1 * PULSE_W'(PULSES_PER_GAIN);
   end

   always_ff @(posedge clk_i) begin
      if (rst_i || clr_i) begin
         t_q <= '0;
         p_q <= '0;
      end else if (run_i) begin
         if (t_q == T_LAST) begin
            t_q <= '0;
            p_q <= p_q + PULSE_W'(1);
         end else begin
            t_q <= t_q + T_W'(1);
         end
      end
   end

   assign t_o    = t_q;
   assign done_o = run_i && (t_q == T_LAST) && (p_q == n_pulses - PULSE_W'(1));

   // R4: the pulse index never runs past the burst length
   a_r4_pulse_in_range: assert property (@(posedge clk_i) disable iff (rst_i)
      run_i |-> (p_q < n_pulses));

   // R7: the slot position stays inside the slot
   a_r7_slot_in_range: assert property (@(posedge clk_i) disable iff (rst_i)
      t_q <= T_LAST);

endmodule

// File: rtl/tm_line_decode.sv
module tm_line_decode #(
   parameter int NUM_X     = 8,
   parameter int NUM_Y     = 4,
   parameter int X_W       = 3,
   parameter int Y_W       = 2,
   parameter int KEY_W     = 5,
   parameter int T_W       = 5,
   parameter int DWELL_W   = 4,
   parameter int SETUP_CYC = 2,
   parameter int XHIGH_CYC = 8
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               prechg_i,
   input  logic               burst_i,
   input  logic               strobe_i,
   input  logic [X_W-1:0]     x_sel_i,
   input  logic [Y_W-1:0]     y_sel_i,
   input  logic [KEY_W-1:0]   key_i,
   input  logic [T_W-1:0]     t_i,
   input  logic [DWELL_W-1:0] dwell_i,
   output logic [NUM_X-1:0]   x_drive_o,
   output logic [NUM_Y-1:0]   y_gate_o,
   output logic [NUM_Y-1:0]   y_gnd_o,
   output logic               cap_reset_o,
   output logic               conv_strobe_o,
   output logic [KEY_W-1:0]   conv_key_o
);

   localparam logic [T_W:0] X_ON  = (T_W+1)'(SETUP_CYC);
   localparam logic [T_W:0] X_OFF = (T_W+1)'(SETUP_CYC + XHIGH_CYC);

   logic [T_W:0]     t_ext;
   logic [T_W:0]     y_end;
   logic             x_win;
   logic             y_win;
   logic [NUM_X-1:0] x_nxt;
   logic [NUM_Y-1:0] y_nxt;
   logic             x_any;
   logic             y_any;

   assign t_ext = {1'b0, t_i};
   assign y_end = X_ON + (T_W+1)'(dwell_i);
   assign x_win = burst_i && (t_ext >= X_ON) && (t_ext < X_OFF);
   assign y_win = burst_i && (t_ext < y_end);

   for (genvar i = 0; i < NUM_X; i++) begin : g_xline
      assign x_nxt[i] = x_win && (x_sel_i == X_W'(i));
   end

   for (genvar j = 0; j < NUM_Y; j++) begin : g_yline
      assign y_nxt[j] = y_win && (y_sel_i == Y_W'(j));
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         x_drive_o     <= '0;
         y_gate_o      <= '0;
         y_gnd_o       <= '1;
         cap_reset_o   <= 1'b0;
         conv_strobe_o <= 1'b0;
         conv_key_o    <= '0;
      end else begin
         x_drive_o     <= x_nxt;
         y_gate_o      <= y_nxt;
         y_gnd_o       <= ~y_nxt;
         cap_reset_o   <= prechg_i;
         conv_strobe_o <= strobe_i;
         if (strobe_i) begin
            conv_key_o <= key_i;
         end
      end
   end

   assign x_any = |x_drive_o;
   assign y_any = |y_gate_o;

   // R3: one X drive and one Y gate at most
   a_r3_x_onehot: assert property (@(posedge clk_i) disable iff (rst_i)
      $onehot0(x_drive_o));
   a_r3_y_onehot: assert property (@(posedge clk_i) disable iff (rst_i)
      $onehot0(y_gate_o));
   // R3: grounding outputs mirror the gates
   a_r3_gnd_inverse: assert property (@(posedge clk_i) disable iff (rst_i)
      y_gnd_o == ~y_gate_o);
   // R5: the gate is already open in the cycle before an X rise
   a_r5_gate_before_rise: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(x_any) |-> $past(y_any));
   // R6: the gate stays open across the rising edge
   a_r6_gate_at_rise: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(x_any) |-> y_any);
   // R8: capacitor reset is directly followed by the gate opening
   a_r8_reset_then_gate: assert property (@(posedge clk_i) disable iff (rst_i)
      cap_reset_o |=> (y_any && !x_any && !cap_reset_o));
   // R9: strobe is a single cycle followed by the next capacitor reset
   a_r9_strobe_then_reset: assert property (@(posedge clk_i) disable iff (rst_i)
      conv_strobe_o |=> (cap_reset_o && !conv_strobe_o));
   // R9: no drive activity while strobing
   a_r9_quiet_strobe: assert property (@(posedge clk_i) disable iff (rst_i)
      conv_strobe_o |-> (!x_any && !y_any));

endmodule

// File: rtl/tm_burst_scan.sv
module tm_burst_scan #(
   parameter int NUM_X           = 8,
   parameter int NUM_Y           = 4,
   parameter int GAIN_W          = 4,
   parameter int DWELL_W         = 4,
   parameter int SETUP_CYC       = 2,
   parameter int XHIGH_CYC       = 8,
   parameter int SPACE_CYC       = 16,
   parameter int PULSES_PER_GAIN = 4
) (
   input  logic                               clk_i,
   input  logic                               rst_i,
   input  logic [NUM_X*NUM_Y*GAIN_W-1:0]      key_gain_i,
   input  logic [NUM_X*NUM_Y*DWELL_W-1:0]     key_dwell_i,
   output logic [NUM_X-1:0]                   x_drive_o,
   output logic [NUM_Y-1:0]                   y_gate_o,
   output logic [NUM_Y-1:0]                   y_gnd_o,
   output logic                               cap_reset_o,
   output logic                               conv_strobe_o,
   output logic [$clog2(NUM_X*NUM_Y)-1:0]     conv_key_o
);

   import tm_scan_pkg::*;

   localparam int NUM_KEYS  = NUM_X * NUM_Y;
   localparam int KEY_W     = $clog2(NUM_KEYS);
   localparam int X_W       = width_of(NUM_X);
   localparam int Y_W       = width_of(NUM_Y);
   localparam int SLOT_CYC  = XHIGH_CYC + SPACE_CYC;
   localparam int T_W       = width_of(SLOT_CYC);
   localparam int DWELL_MAX = (1 << DWELL_W) - 1;
   localparam int PULSE_W   = $clog2(PULSES_PER_GAIN * (1 << GAIN_W) + 1);

   if (NUM_X < 1 || NUM_Y < 1 || NUM_KEYS < 2) begin : g_chk_dims
      $error("tm_burst_scan: matrix needs at least two keys");
   end
   if (SETUP_CYC < 1 || XHIGH_CYC < 1 || SPACE_CYC < 1) begin : g_chk_times
      $error("tm_burst_scan: setup, high and space times must be positive");
   end
   if (SETUP_CYC + DWELL_MAX > SLOT_CYC) begin : g_chk_dwell
      $error("tm_burst_scan: longest gate window overruns the pulse slot");
   end
   if (PULSES_PER_GAIN < 1) begin : g_chk_ppg
      $error("tm_burst_scan: pulses per gain step must be positive");
   end

   scan_state_e        state_q;
   logic [X_W-1:0]     x_idx_q;
   logic [Y_W-1:0]     y_idx_q;
   logic [KEY_W-1:0]   key_idx;
   logic [GAIN_W-1:0]  cfg_gain;
   logic [DWELL_W-1:0] cfg_dwell;
   logic [T_W-1:0]     slot_t;
   logic               burst_done;
   logic               in_prechg;
   logic               in_burst;
   logic               in_strobe;

   assign key_idx   = KEY_W'(x_idx_q) * KEY_W'(NUM_Y) + KEY_W'(y_idx_q);
   assign in_prechg = (state_q == ST_PRECHG);
   assign in_burst  = (state_q == ST_BURST);
   assign in_strobe = (state_q == ST_STROBE);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q <= ST_IDLE;
         x_idx_q <= '0;
         y_idx_q <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE:   state_q <= ST_PRECHG;
            ST_PRECHG: state_q <= ST_BURST;
            ST_BURST:  if (burst_done) state_q <= ST_STROBE;
            ST_STROBE: begin
               state_q <= ST_PRECHG;
               if (y_idx_q == Y_W'(NUM_Y - 1)) begin
                  y_idx_q <= '0;
                  x_idx_q <= (x_idx_q == X_W'(NUM_X - 1)) ? '0 : x_idx_q + X_W'(1);
               end else begin
                  y_idx_q <= y_idx_q + Y_W'(1);
               end
            end
            default:   state_q <= ST_IDLE;
         endcase
      end
   end

   tm_cfg_select #(
      .NUM_KEYS (NUM_KEYS),
      .KEY_W    (KEY_W),
      .GAIN_W   (GAIN_W),
      .DWELL_W  (DWELL_W)
   ) i_cfg (
      .clk_i        (clk_i),
      .rst_i        (rst_i),
      .load_i       (in_prechg),
      .key_i        (key_idx),
      .gain_flat_i  (key_gain_i),
      .dwell_flat_i (key_dwell_i),
      .gain_o       (cfg_gain),
      .dwell_o      (cfg_dwell)
   );

   tm_slot_timer #(
      .SLOT_CYC        (SLOT_CYC),
      .GAIN_W          (GAIN_W),
      .PULSES_PER_GAIN (PULSES_PER_GAIN),
      .PULSE_W         (PULSE_W),
      .T_W             (T_W)
   ) i_timer (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .clr_i  (in_prechg),
      .run_i  (in_burst),
      .gain_i (cfg_gain),
      .t_o    (slot_t),
      .done_o (burst_done)
   );

   tm_line_decode #(
      .NUM_X     (NUM_X),
      .NUM_Y     (NUM_Y),
      .X_W       (X_W),
      .Y_W       (Y_W),
      .KEY_W     (KEY_W),
      .T_W       (T_W),
      .DWELL_W   (DWELL_W),
      .SETUP_CYC (SETUP_CYC),
      .XHIGH_CYC (XHIGH_CYC)
   ) i_decode (
      .clk_i         (clk_i),
      .rst_i         (rst_i),
      .prechg_i      (in_prechg),
      .burst_i       (in_burst),
      .strobe_i      (in_strobe),
      .x_sel_i       (x_idx_q),
      .y_sel_i       (y_idx_q),
      .key_i         (key_idx),
      .t_i           (slot_t),
      .dwell_i       (cfg_dwell),
      .x_drive_o     (x_drive_o),
      .y_gate_o      (y_gate_o),
      .y_gnd_o       (y_gnd_o),
      .cap_reset_o   (cap_reset_o),
      .conv_strobe_o (conv_strobe_o),
      .conv_key_o    (conv_key_o)
   );

   // R2: each strobe advances to the next key, wrapping after the last
   a_r2_key_step: assert property (@(posedge clk_i) disable iff (rst_i)
      in_strobe |=> (key_idx == (($past(key_idx) == KEY_W'(NUM_KEYS - 1)) ?
                                 KEY_W'(0) : $past(key_idx) + KEY_W'(1))));
   // R10: captured configuration stays frozen for the whole burst
   a_r10_cfg_frozen: assert property (@(posedge clk_i) disable iff (rst_i)
      (in_burst && $past(in_burst)) |-> ($stable(cfg_gain) && $stable(cfg_dwell)));
   // R8: a burst is always entered from the capacitor reset state
   a_r8_burst_entry: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(in_burst) |-> $past(in_prechg));

endmodule

// File: tb/test_tm_burst_scan.sv
module test_tm_burst_scan;

   localparam int CLK_PERIOD = 10;
   localparam int NX    = 8;
   localparam int NY    = 4;
   localparam int NK    = NX * NY;
   localparam int SLOT  = 24;
   localparam int SETUP = 2;
   localparam int XH    = 8;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic [NK*4-1:0] gain_v  = '0;
   logic [NK*4-1:0] dwell_v = '0;
   logic [NX-1:0]   x_drive;
   logic [NY-1:0]   y_gate;
   logic [NY-1:0]   y_gnd;
   logic            cap_rst;
   logic            conv_stb;
   logic [4:0]      conv_key;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   int m_lead, m_key, m_pos, m_len, m_np, m_dw;
   int rise_cnt, last_key;
   bit have_key, prev_xany;
   bit hook_en, hook_fired;
   int hook_key;

   always #(CLK_PERIOD/2) clk = ~clk;

   tm_burst_scan i_tm_burst_scan (
      .clk_i         (clk),
      .rst_i         (rst),
      .key_gain_i    (gain_v),
      .key_dwell_i   (dwell_v),
      .x_drive_o     (x_drive),
      .y_gate_o      (y_gate),
      .y_gnd_o       (y_gnd),
      .cap_reset_o   (cap_rst),
      .conv_strobe_o (conv_stb),
      .conv_key_o    (conv_key)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic model_start();
      m_lead = 1; m_key = 0; m_pos = 0; m_len = 1;
      rise_cnt = 0; have_key = 0; prev_xany = 0; hook_fired = 0;
   endtask

   task automatic step_cycle();
      logic [NX-1:0] ex;
      logic [NY-1:0] ey;
      bit ecsr, estb;
      int t;
      ex = '0; ey = '0; ecsr = 0; estb = 0;
      if (m_lead == 0) begin
         if (m_pos == 0) begin
            m_np  = 4 * (int'(gain_v[m_key*4 +: 4]) + 1);
            m_dw  = int'(dwell_v[m_key*4 +: 4]);
            if (m_dw == 0) m_dw = 1;
            m_len = 2 + m_np * SLOT;
            ecsr  = 1;
         end else if (m_pos == m_len - 1) begin
            estb = 1;
         end else begin
            t = (m_pos - 1) % SLOT;
            if (t >= SETUP && t < SETUP + XH) ex[m_key / NY] = 1'b1;
            if (t < SETUP + m_dw) ey[m_key % NY] = 1'b1;
         end
      end
      chk(x_drive == ex, "R7", "x_drive", int'(x_drive), int'(ex));
      chk(y_gate == ey, "R6", "y_gate", int'(y_gate), int'(ey));
      chk(y_gnd == ~y_gate, "R3", "y_gnd", int'(y_gnd), int'(~y_gate));
      chk($countones(x_drive) <= 1, "R3", "x_count", $countones(x_drive), 1);
      chk(cap_rst == ecsr, "R8", "cap_reset", int'(cap_rst), int'(ecsr));
      chk(conv_stb == estb, "R9", "conv_strobe", int'(conv_stb), int'(estb));
      if ((|x_drive) && !prev_xany) begin
         rise_cnt++;
         chk(|y_gate, "R5", "gate_at_rise", int'(y_gate), 1);
      end
      prev_xany = |x_drive;
      if (ecsr) rise_cnt = 0;
      if (estb) begin
         chk(int'(conv_key) == m_key, "R9", "conv_key", int'(conv_key), m_key);
         chk(rise_cnt == m_np, "R4", "pulse_count", rise_cnt, m_np);
         if (have_key)
            chk(int'(conv_key) == (last_key + 1) % NK, "R2", "key_order",
                int'(conv_key), (last_key + 1) % NK);
         if (hook_fired && m_key == hook_key)
            chk(rise_cnt == m_np && m_np == 8, "R10", "old_gain_kept", rise_cnt, 8);
         if (hook_fired && m_key == hook_key + 1)
            chk(rise_cnt == 24, "R10", "new_gain_used", rise_cnt, 24);
         last_key = int'(conv_key);
         have_key = 1;
      end
      if (hook_en && ecsr && m_key == hook_key) begin
         gain_v[hook_key*4 +: 4]      = 4'd5;
         dwell_v[hook_key*4 +: 4]     = 4'd9;
         gain_v[(hook_key+1)*4 +: 4]  = 4'd5;
         dwell_v[(hook_key+1)*4 +: 4] = 4'd9;
         hook_en = 0;
         hook_fired = 1;
      end
      if (m_lead > 0) begin
         m_lead--;
      end else begin
         m_pos++;
         if (m_pos == m_len) begin
            m_pos = 0;
            m_key = (m_key + 1) % NK;
         end
      end
   endtask

   task automatic run_cycles(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         step_cycle();
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk(x_drive == '0, "R1", "x_in_reset", int'(x_drive), 0);
      chk(y_gate == '0, "R1", "y_in_reset", int'(y_gate), 0);
      chk(y_gnd == '1, "R1", "gnd_in_reset", int'(y_gnd), 15);
      chk(!cap_rst && !conv_stb, "R1", "pulses_in_reset",
          int'({cap_rst, conv_stb}), 0);
      chk(conv_key == '0, "R1", "key_in_reset", int'(conv_key), 0);
      rst = 1'b0;
      model_start();
   endtask

   task automatic t_reset_state();
      for (int k = 0; k < NK; k++) begin
         gain_v[k*4 +: 4] = 4'd0;
         dwell_v[k*4 +: 4] = 4'd1;
      end
      do_reset();
      run_cycles(1);
      chk(!cap_rst, "R1", "idle_after_release", int'(cap_rst), 0);
      run_cycles(1);
      chk(cap_rst, "R1", "first_reset_pulse", int'(cap_rst), 1);
      run_cycles(40);
   endtask

   task automatic t_full_scan_wrap();
      for (int k = 0; k < NK; k++) begin
         gain_v[k*4 +: 4] = 4'd0;
         dwell_v[k*4 +: 4] = 4'd1;
      end
      do_reset();
      run_cycles(1 + (NK + 1) * (2 + 4 * SLOT));
      chk(have_key && last_key == 0, "R2", "wrap_to_zero", last_key, 0);
   endtask

   task automatic t_varied_cfg();
      int total;
      total = 1;
      for (int k = 0; k < NK; k++) begin
         gain_v[k*4 +: 4] = 4'((k * 7 + 3) % 16);
         dwell_v[k*4 +: 4] = 4'(k % 16);
      end
      dwell_v[3*4 +: 4] = 4'd15;
      for (int k = 0; k < 8; k++) total += 2 + 4 * ((k * 7 + 3) % 16 + 1) * SLOT;
      do_reset();
      run_cycles(total);
      chk(have_key && last_key == 7, "R4", "varied_last_key", last_key, 7);
   endtask

   task automatic t_cfg_midburst();
      for (int k = 0; k < NK; k++) begin
         gain_v[k*4 +: 4] = 4'd1;
         dwell_v[k*4 +: 4] = 4'd3;
      end
      hook_key = 2;
      do_reset();
      hook_en = 1;
      run_cycles(1 + 3 * (2 + 8 * SLOT) + (2 + 24 * SLOT) + 5);
      chk(hook_fired, "R10", "hook_reached", int'(hook_fired), 1);
      chk(have_key && last_key == 3, "R10", "reached_key3", last_key, 3);
   endtask

   task automatic t_reset_midscan();
      do_reset();
      run_cycles(300);
      do_reset();
      run_cycles(2);
      chk(cap_rst, "R1", "restart_reset_pulse", int'(cap_rst), 1);
      run_cycles(120);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         errors++;
         $display("FAIL R1 watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      hook_en = 0;
      hook_key = 0;
      model_start();
      t_reset_state();
      t_full_scan_wrap();
      t_varied_cfg();
      t_cfg_midburst();
      t_reset_midscan();
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule